// File: doc/BRIEF.md
# Dual-Clock Dual-Port RAM with Burst Address Counters

This block is a synthesizable model of a true dual-port static memory. It has two ports, A and B. Each port has its own clock, and either port can read or write any word at any time. On every rising edge of its clock, a port registers its controls, its write data and an address. The address comes from a per-port burst counter. That counter can take an external address, clear to zero, step by one or hold its value, so a port can sweep a run of consecutive words without presenting a new address each cycle.

A word is split into two byte lanes. Each lane has an active-low select on each port. A write changes only the selected lanes. A read drives a lane only when that lane is selected and the port's output enable is low. Instead of tristate pins, each port returns its read word together with a two-bit lane-drive vector, and undriven lanes read as zero. A static mode input on each port chooses the read path:

- **Flow-through:** the data appears in the cycle after the access is registered.
- **Pipelined:** an extra output register delays the data by one more clock.

The depth is 2^ADDR_W words. Deep configurations use an ADDR_W of 14 to 16, and LANE_W is 8 or 9 bits. The default is kept small.

Top module: `dpr_burst_ram`

## Requirements
- R1: After reset, both ports' lane-drive vectors are 0 and both burst counters hold address 0, so an access with no strobe, clear or step reaches word 0.
- R2: A port is selected only when its `*_ce_n` is 0 and its `*_ce` is 1 at the clock edge. A deselected cycle writes nothing, and it gives a lane-drive of 0 for that access.
- R3: With `*_rw` = 0 on a selected cycle, the port writes the lanes whose `*_lane_n` bit is 0. Bit 0 is the lower lane, data bits [LANE_W-1:0]. Bit 1 is the upper lane, bits [2*LANE_W-1:LANE_W]. Unselected lanes keep their contents.
- R4: With `*_mode_pipe` = 0 (flow-through), a read registered at edge k shows its data and lane-drive between edge k and edge k+1.
- R5: With `*_mode_pipe` = 1 (pipelined), a read registered at edge k shows its data and lane-drive between edge k+1 and edge k+2. In the cycle before that, the drive of an idle preceding cycle shows instead.
- R6: `*_drv[i]` is 1 only for a read access with lane i selected and `*_oe_n` = 0. The output enable acts without a clock. Data bits of undriven lanes are 0.
- R7: `*_ads_n` = 0 makes the access use `*_addr` and loads it into the burst counter.
- R8: `*_cnten_n` = 0 steps the counter by one per edge, and it is ignored when `*_ads_n` or `*_cntrst_n` is 0.
- R9: `*_cntrst_n` = 0 clears the counter to 0 and takes priority over both the strobe and the step.
- R10: A step from address 2^ADDR_W-1 wraps to 0. With the strobe, clear and step all inactive, the counter keeps its value.
- R11: A word written by one port is readable from the other port. A read on one port registered in the same cycle as a write to the same word on the other port returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Active-low asynchronous reset of port registers |
| a_mode_pipe | input | 1 | Port A read path: 0 flow-through, 1 pipelined |
| a_ce_n | input | 1 | Port A active-low chip enable |
| a_ce | input | 1 | Port A active-high chip enable |
| a_rw | input | 1 | Port A 1 read, 0 write |
| a_lane_n | input | 2 | Port A active-low lane selects (bit 0 lower) |
| a_oe_n | input | 1 | Port A active-low output enable |
| a_ads_n | input | 1 | Port A active-low address strobe |
| a_cnten_n | input | 1 | Port A active-low counter step |
| a_cntrst_n | input | 1 | Port A active-low counter clear |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | 2*LANE_W | Port A write data |
| a_rdata | output | 2*LANE_W | Port A read data, undriven lanes zero |
| a_drv | output | 2 | Port A lane-drive vector |
| b_mode_pipe | input | 1 | Port B read path select |
| b_ce_n | input | 1 | Port B active-low chip enable |
| b_ce | input | 1 | Port B active-high chip enable |
| b_rw | input | 1 | Port B 1 read, 0 write |
| b_lane_n | input | 2 | Port B active-low lane selects |
| b_oe_n | input | 1 | Port B active-low output enable |
| b_ads_n | input | 1 | Port B active-low address strobe |
| b_cnten_n | input | 1 | Port B active-low counter step |
| b_cntrst_n | input | 1 | Port B active-low counter clear |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | 2*LANE_W | Port B write data |
| b_rdata | output | 2*LANE_W | Port B read data, undriven lanes zero |
| b_drv | output | 2 | Port B lane-drive vector |

## Verification
The hardest case to reach from the ports is a read on one port that lands in the same cycle as the other port's write to the same word. That read must return the old contents, and the very next read must return the new ones. The stimulus first writes a known value through port A. It then issues a second write on A and a strobed read on B in the same cycle, and finally repeats the B read by holding its counter. The wrap of the counter at the top address is reached by strobing the last word and then stepping once. The counter-clear priority is reached by asserting clear, strobe and step together.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANES = 2;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] ext,
    input  logic              ads_n,
    input  logic              cnten_n,
    input  logic              cntrst_n,
    output logic [ADDR_W-1:0] nxt
);
    // Priority: clear, then strobe load, then step, else hold.
    always_comb begin
        if (!cntrst_n)
            nxt = '0;
        else if (!ads_n)
            nxt = ext;
        else if (!cnten_n)
            nxt = cur + 1'b1;
        else
            nxt = cur;
    end
endmodule

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [LANE_W-1:0] wd_a,
    output logic [LANE_W-1:0] rd_a,
    input  logic              clk_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [LANE_W-1:0] wd_b,
    output logic [LANE_W-1:0] rd_b
);
    localparam int DEPTH = 1 << ADDR_W;

    // One store per writing clock; per-word tags tell which store is newer.
    logic [LANE_W-1:0] store_a [DEPTH];
    logic [LANE_W-1:0] store_b [DEPTH];
    logic              tag_a   [DEPTH];
    logic              tag_b   [DEPTH];

    always_ff @(posedge clk_a) begin
        if (we_a) begin
            store_a[addr_a] <= wd_a;
            tag_a[addr_a]   <= tag_b[addr_a];
        end
    end

    always_ff @(posedge clk_b) begin
        if (we_b) begin
            store_b[addr_b] <= wd_b;
            tag_b[addr_b]   <= ~tag_a[addr_b];
        end
    end

    always_comb begin
        rd_a = (tag_a[addr_a] == tag_b[addr_a]) ? store_a[addr_a] : store_b[addr_a];
        rd_b = (tag_a[addr_b] == tag_b[addr_b]) ? store_a[addr_b] : store_b[addr_b];
    end
endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_pipe,
    input  logic                    ce_n,
    input  logic                    ce,
    input  logic                    rw,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    oe_n,
    input  logic                    ads_n,
    input  logic                    cnten_n,
    input  logic                    cntrst_n,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic [LANES*LANE_W-1:0] wdata_in,
    input  logic [LANES*LANE_W-1:0] rd_word,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES-1:0]        wr_lane,
    output logic [LANES*LANE_W-1:0] wr_word,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        drv
);
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              s1_rd;
        logic              s1_wr;
        logic [LANES-1:0]  s1_lane;
        logic [WORD_W-1:0] s1_wd;
        logic              s2_rd;
        logic [LANES-1:0]  s2_lane;
        logic [WORD_W-1:0] s2_word;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic              sel;
    rd_mode_e          mode;
    logic              rd_v;
    logic [LANES-1:0]  lane_v;
    logic [WORD_W-1:0] word_v;

    dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .cur      (st_q.addr),
        .ext      (addr_in),
        .ads_n    (ads_n),
        .cnten_n  (cnten_n),
        .cntrst_n (cntrst_n),
        .nxt      (addr_nxt)
    );

    assign sel  = ~ce_n & ce;
    assign mode = rd_mode_e'(mode_pipe);

    always_comb begin
        st_d         = st_q;
        st_d.addr    = addr_nxt;
        st_d.s1_rd   = sel & rw;
        st_d.s1_wr   = sel & ~rw;
        st_d.s1_lane = ~lane_n;
        st_d.s1_wd   = wdata_in;
        st_d.s2_rd   = st_q.s1_rd;
        st_d.s2_lane = st_q.s1_lane;
        st_d.s2_word = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign mem_addr = st_q.addr;
    assign wr_lane  = {LANES{st_q.s1_wr}} & st_q.s1_lane;
    assign wr_word  = st_q.s1_wd;

    always_comb begin
        if (mode == RD_PIPE) begin
            rd_v   = st_q.s2_rd;
            lane_v = st_q.s2_lane;
            word_v = st_q.s2_word;
        end else begin
            rd_v   = st_q.s1_rd;
            lane_v = st_q.s1_lane;
            word_v = rd_word;
        end
        drv = {LANES{rd_v & ~oe_n}} & lane_v;
        for (int l = 0; l < LANES; l++)
            rdata[l*LANE_W +: LANE_W] = drv[l] ? word_v[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                    clk_a,
    input  logic                    clk_b,
    input  logic                    rst_n,
    input  logic                    a_mode_pipe,
    input  logic                    a_ce_n,
    input  logic                    a_ce,
    input  logic                    a_rw,
    input  logic [1:0]              a_lane_n,
    input  logic                    a_oe_n,
    input  logic                    a_ads_n,
    input  logic                    a_cnten_n,
    input  logic                    a_cntrst_n,
    input  logic [ADDR_W-1:0]       a_addr,
    input  logic [2*LANE_W-1:0]     a_wdata,
    output logic [2*LANE_W-1:0]     a_rdata,
    output logic [1:0]              a_drv,
    input  logic                    b_mode_pipe,
    input  logic                    b_ce_n,
    input  logic                    b_ce,
    input  logic                    b_rw,
    input  logic [1:0]              b_lane_n,
    input  logic                    b_oe_n,
    input  logic                    b_ads_n,
    input  logic                    b_cnten_n,
    input  logic                    b_cntrst_n,
    input  logic [ADDR_W-1:0]       b_addr,
    input  logic [2*LANE_W-1:0]     b_wdata,
    output logic [2*LANE_W-1:0]     b_rdata,
    output logic [1:0]              b_drv
);
    localparam int WORD_W = LANES * LANE_W;

    logic [ADDR_W-1:0] a_cur_addr, b_cur_addr;
    logic [LANES-1:0]  a_wr_lane, b_wr_lane;
    logic [WORD_W-1:0] a_wr_word, b_wr_word;
    logic [WORD_W-1:0] a_rd_word, b_rd_word;

    dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_port_a (
        .clk (clk_a), .rst_n (rst_n), .mode_pipe (a_mode_pipe),
        .ce_n (a_ce_n), .ce (a_ce), .rw (a_rw), .lane_n (a_lane_n),
        .oe_n (a_oe_n), .ads_n (a_ads_n), .cnten_n (a_cnten_n),
        .cntrst_n (a_cntrst_n), .addr_in (a_addr), .wdata_in (a_wdata),
        .rd_word (a_rd_word), .mem_addr (a_cur_addr), .wr_lane (a_wr_lane),
        .wr_word (a_wr_word), .rdata (a_rdata), .drv (a_drv)
    );

    dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_port_b (
        .clk (clk_b), .rst_n (rst_n), .mode_pipe (b_mode_pipe),
        .ce_n (b_ce_n), .ce (b_ce), .rw (b_rw), .lane_n (b_lane_n),
        .oe_n (b_oe_n), .ads_n (b_ads_n), .cnten_n (b_cnten_n),
        .cntrst_n (b_cntrst_n), .addr_in (b_addr), .wdata_in (b_wdata),
        .rd_word (b_rd_word), .mem_addr (b_cur_addr), .wr_lane (b_wr_lane),
        .wr_word (b_wr_word), .rdata (b_rdata), .drv (b_drv)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dpr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk_a  (clk_a),
            .we_a   (a_wr_lane[l]),
            .addr_a (a_cur_addr),
            .wd_a   (a_wr_word[l*LANE_W +: LANE_W]),
            .rd_a   (a_rd_word[l*LANE_W +: LANE_W]),
            .clk_b  (clk_b),
            .we_b   (b_wr_lane[l]),
            .addr_b (b_cur_addr),
            .wd_b   (b_wr_word[l*LANE_W +: LANE_W]),
            .rd_b   (b_rd_word[l*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/dpr_burst_chk.sv
module dpr_burst_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic              a_mode_pipe,
    input logic              a_ce_n,
    input logic              a_ce,
    input logic              a_oe_n,
    input logic              a_ads_n,
    input logic              a_cnten_n,
    input logic              a_cntrst_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic [1:0]        a_drv,
    input logic [ADDR_W-1:0] a_cur_addr,
    input logic              b_oe_n,
    input logic              b_cntrst_n,
    input logic [1:0]        b_drv,
    input logic [ADDR_W-1:0] b_cur_addr
);
    p_clear_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_cntrst_n |=> a_cur_addr == '0);

    p_load_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_cntrst_n && !a_ads_n |=> a_cur_addr == $past(a_addr));

    p_step_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_cntrst_n && a_ads_n && !a_cnten_n |=>
        a_cur_addr == ADDR_W'($past(a_cur_addr) + 1'b1));

    p_hold_r10: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_cntrst_n && a_ads_n && a_cnten_n |=> $stable(a_cur_addr));

    p_oe_gate_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_oe_n |-> a_drv == 2'b00);

    p_desel_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_mode_pipe && !(!a_ce_n && a_ce) |=> (a_mode_pipe || a_drv == 2'b00));

    p_clear_b_r9: assert property (@(posedge clk_b) disable iff (!rst_n)
        !b_cntrst_n |=> b_cur_addr == '0);

    p_oe_gate_b_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
        b_oe_n |-> b_drv == 2'b00);
endmodule

bind dpr_burst_ram dpr_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_a       (clk_a),
    .clk_b       (clk_b),
    .rst_n       (rst_n),
    .a_mode_pipe (a_mode_pipe),
    .a_ce_n      (a_ce_n),
    .a_ce        (a_ce),
    .a_oe_n      (a_oe_n),
    .a_ads_n     (a_ads_n),
    .a_cnten_n   (a_cnten_n),
    .a_cntrst_n  (a_cntrst_n),
    .a_addr      (a_addr),
    .a_drv       (a_drv),
    .a_cur_addr  (a_cur_addr),
    .b_oe_n      (b_oe_n),
    .b_cntrst_n  (b_cntrst_n),
    .b_drv       (b_drv),
    .b_cur_addr  (b_cur_addr)
);

// File: tb/dpr_burst_ram_test.sv
module dpr_burst_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;

    typedef struct packed {
        logic          port;
        logic          wr;
        logic [1:0]    lane_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] exp;
        logic [1:0]    drv;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 1'b1, 2'b00, 10'h010, 16'hA1B2, 16'h0000, 2'b00},
        '{1'b1, 1'b1, 2'b00, 10'h011, 16'hC3D4, 16'h0000, 2'b00},
        '{1'b0, 1'b1, 2'b10, 10'h010, 16'hEEFF, 16'h0000, 2'b00},
        '{1'b0, 1'b0, 2'b00, 10'h010, 16'h0000, 16'hA1FF, 2'b11},
        '{1'b1, 1'b0, 2'b01, 10'h010, 16'h0000, 16'hA100, 2'b10},
        '{1'b1, 1'b0, 2'b00, 10'h011, 16'h0000, 16'hC3D4, 2'b11},
        '{1'b0, 1'b0, 2'b10, 10'h011, 16'h0000, 16'h00D4, 2'b01},
        '{1'b1, 1'b1, 2'b00, 10'h3FF, 16'h1234, 16'h0000, 2'b00},
        '{1'b0, 1'b0, 2'b00, 10'h3FF, 16'h0000, 16'h1234, 2'b11}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_mode_pipe = 0, a_ce_n = 1, a_ce = 0, a_rw = 1, a_oe_n = 0;
    logic a_ads_n = 1, a_cnten_n = 1, a_cntrst_n = 1;
    logic [1:0] a_lane_n = 2'b11;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_wdata = '0;
    logic b_mode_pipe = 0, b_ce_n = 1, b_ce = 0, b_rw = 1, b_oe_n = 0;
    logic b_ads_n = 1, b_cnten_n = 1, b_cntrst_n = 1;
    logic [1:0] b_lane_n = 2'b11;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic [1:0] a_drv, b_drv;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpr_burst_ram #(.ADDR_W(AW), .LANE_W(8)) uut (
        .clk_a (clk), .clk_b (clk), .rst_n (rst_n),
        .a_mode_pipe (a_mode_pipe), .a_ce_n (a_ce_n), .a_ce (a_ce), .a_rw (a_rw),
        .a_lane_n (a_lane_n), .a_oe_n (a_oe_n), .a_ads_n (a_ads_n),
        .a_cnten_n (a_cnten_n), .a_cntrst_n (a_cntrst_n), .a_addr (a_addr),
        .a_wdata (a_wdata), .a_rdata (a_rdata), .a_drv (a_drv),
        .b_mode_pipe (b_mode_pipe), .b_ce_n (b_ce_n), .b_ce (b_ce), .b_rw (b_rw),
        .b_lane_n (b_lane_n), .b_oe_n (b_oe_n), .b_ads_n (b_ads_n),
        .b_cnten_n (b_cnten_n), .b_cntrst_n (b_cntrst_n), .b_addr (b_addr),
        .b_wdata (b_wdata), .b_rdata (b_rdata), .b_drv (b_drv)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp,
                       input logic [1:0] gd, input logic [1:0] ed);
        total++;
        if (got !== exp || gd !== ed) begin
            bad++;
            $display("FAIL %s: actual data=%h drv=%b expected data=%h drv=%b",
                     req, got, gd, exp, ed);
        end
    endtask

    // sel=1 gives ce_n=0, ce=1; sel=0 gives ce_n=1, ce=0.
    task automatic port_set(input int p, input logic sel, input logic wr,
                            input logic [1:0] ln, input logic ads, input logic cen,
                            input logic crst, input logic [AW-1:0] ad,
                            input logic [DW-1:0] wd);
        if (p == 0) begin
            a_ce_n = ~sel; a_ce = sel; a_rw = ~wr; a_lane_n = ln;
            a_ads_n = ads; a_cnten_n = cen; a_cntrst_n = crst;
            a_addr = ad; a_wdata = wd;
        end else begin
            b_ce_n = ~sel; b_ce = sel; b_rw = ~wr; b_lane_n = ln;
            b_ads_n = ads; b_cnten_n = cen; b_cntrst_n = crst;
            b_addr = ad; b_wdata = wd;
        end
    endtask

    task automatic idle(input int p);
        port_set(p, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: drive vectors idle during reset
        chk("R1 reset drive A", a_rdata, 16'h0000, a_drv, 2'b00);
        chk("R1 reset drive B", b_rdata, 16'h0000, b_drv, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R10: B writes word 0, A reads through its cleared, held counter
        port_set(1, 1, 1, 2'b00, 0, 1, 1, 10'h000, 16'h5A5A);
        @(negedge clk);
        idle(1);
        port_set(0, 1, 0, 2'b00, 1, 1, 1, 10'h155, 16'h0000);
        @(negedge clk);
        chk("R1 counter zero after reset", a_rdata, 16'h5A5A, a_drv, 2'b11);
        idle(0);

        // Vector table: R3 lane writes, R4 flow-through, R6 lane gating, R7 strobe, R11 cross-port
        for (int i = 0; i < NVEC; i++) begin
            port_set(VECS[i].port, 1, VECS[i].wr, VECS[i].lane_n, 0, 1, 1,
                     VECS[i].addr, VECS[i].data);
            idle(VECS[i].port ? 0 : 1);
            @(negedge clk);
            if (!VECS[i].wr) begin
                if (VECS[i].port)
                    chk("R3/R4/R6/R7/R11 vector B", b_rdata, VECS[i].exp, b_drv, VECS[i].drv);
                else
                    chk("R3/R4/R6/R7/R11 vector A", a_rdata, VECS[i].exp, a_drv, VECS[i].drv);
            end
        end
        idle(0); idle(1);

        // R2: write with ce_n=0 but ce=0 must not land
        port_set(0, 1, 1, 2'b00, 0, 1, 1, 10'h010, 16'h0000);
        a_ce = 1'b0;
        @(negedge clk);
        port_set(0, 1, 0, 2'b00, 0, 1, 1, 10'h010, 16'h0000);
        @(negedge clk);
        chk("R2 deselected write ignored", a_rdata, 16'hA1FF, a_drv, 2'b11);
        // R2: read with ce_n=1, ce=1 gives no drive
        port_set(0, 1, 0, 2'b00, 0, 1, 1, 10'h011, 16'h0000);
        a_ce_n = 1'b1;
        @(negedge clk);
        chk("R2 deselected read", a_rdata, 16'h0000, a_drv, 2'b00);

        // R6: output enable acts without a clock
        port_set(0, 1, 0, 2'b00, 0, 1, 1, 10'h011, 16'h0000);
        a_oe_n = 1'b1;
        @(negedge clk);
        chk("R6 oe_n high", a_rdata, 16'h0000, a_drv, 2'b00);
        a_oe_n = 1'b0;
        #1;
        chk("R6 oe_n low same cycle", a_rdata, 16'hC3D4, a_drv, 2'b11);

        // R5: pipelined latency
        a_mode_pipe = 1'b1;
        idle(0);
        @(negedge clk);
        port_set(0, 1, 0, 2'b00, 0, 1, 1, 10'h011, 16'h0000);
        @(negedge clk);
        chk("R5 pipelined not yet", a_rdata, 16'h0000, a_drv, 2'b00);
        idle(0);
        @(negedge clk);
        chk("R5 pipelined data", a_rdata, 16'hC3D4, a_drv, 2'b11);
        a_mode_pipe = 1'b0;
        @(negedge clk);

        // R8: burst write on A, burst read on B
        port_set(0, 1, 1, 2'b00, 0, 1, 1, 10'h020, 16'h1000);
        @(negedge clk);
        port_set(0, 1, 1, 2'b00, 1, 0, 1, 10'h000, 16'h1001);
        @(negedge clk);
        port_set(0, 1, 1, 2'b00, 1, 0, 1, 10'h000, 16'h1002);
        @(negedge clk);
        idle(0);
        port_set(1, 1, 0, 2'b00, 0, 0, 1, 10'h020, 16'h0000);
        @(negedge clk);
        chk("R8 step ignored under strobe", b_rdata, 16'h1000, b_drv, 2'b11);
        port_set(1, 1, 0, 2'b00, 1, 0, 1, 10'h000, 16'h0000);
        @(negedge clk);
        chk("R8 burst step 1", b_rdata, 16'h1001, b_drv, 2'b11);
        @(negedge clk);
        chk("R8 burst step 2", b_rdata, 16'h1002, b_drv, 2'b11);

        // R9: clear beats strobe and step
        port_set(1, 1, 0, 2'b00, 0, 0, 0, 10'h011, 16'h0000);
        @(negedge clk);
        chk("R9 clear priority", b_rdata, 16'h5A5A, b_drv, 2'b11);
        idle(1);

        // R10: wrap and hold
        port_set(0, 1, 0, 2'b00, 0, 1, 1, 10'h3FF, 16'h0000);
        @(negedge clk);
        chk("R10 top word", a_rdata, 16'h1234, a_drv, 2'b11);
        port_set(0, 1, 0, 2'b00, 1, 0, 1, 10'h000, 16'h0000);
        @(negedge clk);
        chk("R10 wrap to zero", a_rdata, 16'h5A5A, a_drv, 2'b11);
        port_set(0, 1, 0, 2'b00, 1, 1, 1, 10'h2AA, 16'h0000);
        @(negedge clk);
        chk("R10 hold", a_rdata, 16'h5A5A, a_drv, 2'b11);

        // R11: read on B while A writes the same word
        port_set(0, 1, 1, 2'b00, 0, 1, 1, 10'h030, 16'h1111);
        @(negedge clk);
        port_set(0, 1, 1, 2'b00, 0, 1, 1, 10'h030, 16'h2222);
        port_set(1, 1, 0, 2'b00, 0, 1, 1, 10'h030, 16'h0000);
        @(negedge clk);
        chk("R11 old data on collision", b_rdata, 16'h1111, b_drv, 2'b11);
        idle(0);
        port_set(1, 1, 0, 2'b00, 1, 1, 1, 10'h000, 16'h0000);
        @(negedge clk);
        chk("R11 new data after", b_rdata, 16'h2222, b_drv, 2'b11);
        idle(1);
        @(negedge clk);

        finished = 1;
        summary();
    end
endmodule